// File: doc/BRIEF.md
# Closed Caption Line Inserter

This block produces the digital sample levels of the caption data waveform for an interlaced video encoder. It watches the line number and the sample position coming from the video timing generator. When the first-field caption line or the second-field caption line comes round and insertion is enabled for that field, it emits a fixed sequence, starting a programmable number of samples into the line. The sequence is a run-in burst, then a start pattern, then two caption characters with computed parity. Each field has its own enable, its own pair of host-loaded characters and its own interrupt flag.

The host loads a pair of 7-bit characters into a field's holding register. The pair is taken when that field's caption line begins. Once the last bit has been sent, the field's interrupt flag is raised, which asks the host for the next pair. If no fresh pair has been loaded by the next caption line, the block sends null characters. While the waveform is running, a select output is high so that downstream logic can replace the video on that line with the caption levels.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset, `cc_sel` is low, `cc_level` equals the blanking level, both bits of `irq_flag` are 0 and `irq` is low.
- R2: Insertion starts in the clock cycle that follows the rising edge at which `line_num` equals `LINE_F1` (bit 0 of the field encoding) or `LINE_F2` (bit 1), `sample_pos` equals `START_OFS` and the matching `cap_en` bit is 1. `cc_sel` is then high for exactly 26·`BIT_PCLK` cycles.
- R3: The two `cap_en` bits act independently. On a line whose enable is 0, and on any other line, `cc_sel` stays low and `cc_level` stays at blanking. On such a line the field's loaded pair is not consumed and its interrupt flag is not touched.
- R4: Bit periods 0 to 6 form the run-in. In each of them the level is high for the first `BIT_PCLK/2` samples and blanking for the rest.
- R5: Bit periods 7 and 8 are 0 and bit period 9 is 1 (start pattern).
- R6: Bit periods 10 to 25 carry the first character (`host_pair` bits [6:0]), LSB first, followed by its odd parity bit. The second character (bits [13:7]) follows in the same way. Period 10 is bit 0 of the first character, period 17 is its parity bit, and period 25 is the parity bit of the second character.
- R7: A pair is consumed when its line starts. If the field's register has not been written since its last consumption, or since reset, both characters are sent as null: seven 0 bits and then a parity bit of 1.
- R8: The field's `irq_flag` bit goes high on the same edge at which `cc_sel` falls. It stays high until a cycle with that field's `irq_clr` bit at 1. If a set and a clear fall in the same cycle, the set wins. `irq` is the OR of both flags.
- R9: A bit value of 1 is output as `LVL_HIGH` and a bit value of 0 as `LVL_BLANK`. Whenever `cc_sel` is low the output is `LVL_BLANK`.
- R10: A write to a field's register while its line is being sent does not change the waveform in progress. The written pair is sent on that field's next caption line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_num | input | LINE_W | Current line number from timing generator |
| sample_pos | input | POS_W | Sample index within the line, 0 at line start |
| cap_en | input | 2 | Per-field insertion enable (bit 0 first field, bit 1 second field) |
| host_wr | input | 2 | Per-field one-cycle write strobe for the character pair |
| host_pair_f1 | input | 14 | First-field pair: [6:0] first char, [13:7] second char |
| host_pair_f2 | input | 14 | Second-field pair, same layout |
| irq_clr | input | 2 | Write-1-to-clear strobes for the interrupt flags |
| cc_level | output | LEVEL_W | Caption sample level |
| cc_sel | output | 1 | High while the caption waveform is being output |
| irq_flag | output | 2 | Per-field transmission-done flags |
| irq | output | 1 | OR of the flags |

## Verification
The hardest case to reach from the ports is a host clear that arrives on exactly the edge where the last caption sample ends and the flag is set. A second hard case is a host write that lands while the pair it replaces is still being shifted out. The bench drives the sample position itself, so it knows the precise edge on which each transmission ends. Its line task can aim a clear strobe or a register write at any chosen sample index, and the directed runs place them on the final edge and in the middle of the data bits. The random runs then scatter writes, clears and enables around those points.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int RUNIN_BITS = 7;
    localparam int START_BITS = 3;
    localparam int CHAR_BITS  = 7;
    localparam int DATA_BITS  = 2 * (CHAR_BITS + 1);
    localparam int FRAME_BITS = RUNIN_BITS + START_BITS + DATA_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic {
        FLD_ONE = 1'b0,
        FLD_TWO = 1'b1
    } field_e;

    typedef enum logic [1:0] {
        SEG_RUNIN = 2'd0,
        SEG_LOW   = 2'd1,
        SEG_HIGH  = 2'd2,
        SEG_DATA  = 2'd3
    } seg_e;

    typedef struct packed {
        logic [CHAR_BITS-1:0] c2;
        logic [CHAR_BITS-1:0] c1;
    } cc_pair_t;

    function automatic logic odd_par(input logic [CHAR_BITS-1:0] ch);
        return ~(^ch);
    endfunction

    function automatic logic [DATA_BITS-1:0] build_frame(input cc_pair_t pr,
                                                          input logic fresh);
        if (fresh)
            return {odd_par(pr.c2), pr.c2, odd_par(pr.c1), pr.c1};
        return {1'b1, {CHAR_BITS{1'b0}}, 1'b1, {CHAR_BITS{1'b0}}};
    endfunction

    function automatic seg_e seg_of(input logic [IDX_W-1:0] idx);
        if (idx < IDX_W'(RUNIN_BITS))
            return SEG_RUNIN;
        if (idx < IDX_W'(RUNIN_BITS + START_BITS - 1))
            return SEG_LOW;
        if (idx == IDX_W'(RUNIN_BITS + START_BITS - 1))
            return SEG_HIGH;
        return SEG_DATA;
    endfunction

endpackage

// File: rtl/cc_pair_store.sv
module cc_pair_store
    import cc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  cc_pair_t wr_pair,
    input  logic     take,
    output cc_pair_t pair,
    output logic     fresh
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pair  <= '0;
            fresh <= 1'b0;
        end else if (wr) begin
            pair  <= wr_pair;
            fresh <= 1'b1;
        end else if (take) begin
            fresh <= 1'b0;
        end
    end

endmodule

// File: rtl/cc_irq_flags.sv
module cc_irq_flags #(
    parameter int NFLD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NFLD-1:0] set,
    input  logic [NFLD-1:0] clr,
    output logic [NFLD-1:0] flag
);

    for (genvar g = 0; g < NFLD; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag[g] <= 1'b0;
            else if (set[g])
                flag[g] <= 1'b1;
            else if (clr[g])
                flag[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/cc_bit_sequencer.sv
module cc_bit_sequencer
    import cc_pkg::*;
#(
    parameter int BIT_PCLK = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  field_e               start_fld,
    input  logic [DATA_BITS-1:0] frame_in,
    output logic                 busy,
    output logic                 bit_val,
    output logic                 done,
    output field_e               done_fld
);

    localparam int PIX_W = (BIT_PCLK > 2) ? $clog2(BIT_PCLK) : 1;
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(BIT_PCLK - 1);
    localparam logic [PIX_W-1:0] PIX_HALF = PIX_W'(BIT_PCLK / 2);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

    logic [PIX_W-1:0]     pix_q;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_BITS-1:0] sh_q;
    field_e               fld_q;
    seg_e                 seg;
    logic                 bit_end;

    assign seg      = seg_of(idx_q);
    assign bit_end  = (pix_q == PIX_LAST);
    assign done     = busy && bit_end && (idx_q == IDX_LAST);
    assign done_fld = fld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pix_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            fld_q <= FLD_ONE;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            pix_q <= '0;
            idx_q <= '0;
            sh_q  <= frame_in;
            fld_q <= start_fld;
        end else if (busy) begin
            if (bit_end) begin
                pix_q <= '0;
                if (seg == SEG_DATA)
                    sh_q <= sh_q >> 1;
                if (idx_q == IDX_LAST)
                    busy <= 1'b0;
                else
                    idx_q <= idx_q + 1'b1;
            end else begin
                pix_q <= pix_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (seg)
            SEG_RUNIN: bit_val = (pix_q < PIX_HALF);
            SEG_LOW:   bit_val = 1'b0;
            SEG_HIGH:  bit_val = 1'b1;
            SEG_DATA:  bit_val = sh_q[0];
            default:   bit_val = 1'b0;
        endcase
    end

endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter
    import cc_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int POS_W     = 12,
    parameter int LEVEL_W   = 10,
    parameter int BIT_PCLK  = 32,
    parameter int START_OFS = 120,
    parameter int LINE_F1   = 21,
    parameter int LINE_F2   = 284,
    parameter logic [LEVEL_W-1:0] LVL_BLANK = 10'd240,
    parameter logic [LEVEL_W-1:0] LVL_HIGH  = 10'd560
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LINE_W-1:0]  line_num,
    input  logic [POS_W-1:0]   sample_pos,
    input  logic [1:0]         cap_en,
    input  logic [1:0]         host_wr,
    input  logic [13:0]        host_pair_f1,
    input  logic [13:0]        host_pair_f2,
    input  logic [1:0]         irq_clr,
    output logic [LEVEL_W-1:0] cc_level,
    output logic               cc_sel,
    output logic [1:0]         irq_flag,
    output logic               irq
);

    localparam int NFLD = 2;
    localparam logic [LINE_W-1:0] LN_F1 = LINE_W'(LINE_F1);
    localparam logic [LINE_W-1:0] LN_F2 = LINE_W'(LINE_F2);
    localparam logic [POS_W-1:0]  POS0  = POS_W'(START_OFS);

    cc_pair_t [NFLD-1:0]  wr_pair;
    cc_pair_t [NFLD-1:0]  cur_pair;
    logic [NFLD-1:0]      fresh;
    logic [NFLD-1:0]      take;
    logic [NFLD-1:0]      trig;
    logic [NFLD-1:0]      set_irq;
    logic [DATA_BITS-1:0] frame;
    logic                 at_ofs;
    logic                 start;
    field_e               start_fld;
    logic                 busy;
    logic                 bit_val;
    logic                 done;
    field_e               done_fld;

    assign wr_pair[0] = cc_pair_t'(host_pair_f1);
    assign wr_pair[1] = cc_pair_t'(host_pair_f2);

    assign at_ofs  = (sample_pos == POS0);
    assign trig[0] = at_ofs && cap_en[0] && (line_num == LN_F1);
    assign trig[1] = at_ofs && cap_en[1] && (line_num == LN_F2);

    assign start     = (|trig) && !busy;
    assign start_fld = trig[0] ? FLD_ONE : FLD_TWO;
    assign frame     = build_frame(cur_pair[start_fld], fresh[start_fld]);

    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        assign take[f]    = start && (start_fld == field_e'(f));
        assign set_irq[f] = done && (done_fld == field_e'(f));

        cc_pair_store u_store (
            .clk     (clk),
            .rst     (rst),
            .wr      (host_wr[f]),
            .wr_pair (wr_pair[f]),
            .take    (take[f]),
            .pair    (cur_pair[f]),
            .fresh   (fresh[f])
        );
    end

    cc_bit_sequencer #(
        .BIT_PCLK (BIT_PCLK)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_fld (start_fld),
        .frame_in  (frame),
        .busy      (busy),
        .bit_val   (bit_val),
        .done      (done),
        .done_fld  (done_fld)
    );

    cc_irq_flags #(
        .NFLD (NFLD)
    ) u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (set_irq),
        .clr  (irq_clr),
        .flag (irq_flag)
    );

    assign cc_sel   = busy;
    assign cc_level = (busy && bit_val) ? LVL_HIGH : LVL_BLANK;
    assign irq      = |irq_flag;

endmodule

// File: rtl/cc_line_inserter_chk.sv
module cc_line_inserter_chk #(
    parameter int LINE_W    = 10,
    parameter int POS_W     = 12,
    parameter int LEVEL_W   = 10,
    parameter int BIT_PCLK  = 32,
    parameter int START_OFS = 120,
    parameter int LINE_F1   = 21,
    parameter int LINE_F2   = 284,
    parameter logic [LEVEL_W-1:0] LVL_BLANK = 10'd240
) (
    input logic               clk,
    input logic               rst,
    input logic [LINE_W-1:0]  line_num,
    input logic [POS_W-1:0]   sample_pos,
    input logic [1:0]         irq_clr,
    input logic [LEVEL_W-1:0] cc_level,
    input logic               cc_sel,
    input logic [1:0]         irq_flag,
    input logic               irq
);

    localparam int TOTAL = cc_pkg::FRAME_BITS * BIT_PCLK;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (cc_sel)
            run_cnt <= run_cnt + 1'b1;
        else
            run_cnt <= '0;
    end

    // R9: outside the caption window the level is blanking
    a_r9_blank_idle: assert property (@(posedge clk) disable iff (rst)
        !cc_sel |-> cc_level == LVL_BLANK);

    // R2: a caption window begins only after the offset sample of a caption line
    a_r2_start_point: assert property (@(posedge clk) disable iff (rst)
        $rose(cc_sel) |-> ($past(sample_pos) == POS_W'(START_OFS)) &&
            (($past(line_num) == LINE_W'(LINE_F1)) || ($past(line_num) == LINE_W'(LINE_F2))));

    // R2: the window never exceeds its fixed length
    a_r2_max_len: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CW'(TOTAL));

    // R2: the window ends exactly after its full length
    a_r2_full_len: assert property (@(posedge clk) disable iff (rst)
        $fell(cc_sel) |-> $past(run_cnt) == CW'(TOTAL - 1));

    // R8: a flag rises only when a transmission ends
    a_r8_rise_on_end0: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag[0]) |-> $fell(cc_sel));
    a_r8_rise_on_end1: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag[1]) |-> $fell(cc_sel));

    // R8: a flag holds until a clear strobe
    a_r8_hold0: assert property (@(posedge clk) disable iff (rst)
        (irq_flag[0] && !irq_clr[0]) |=> irq_flag[0]);
    a_r8_hold1: assert property (@(posedge clk) disable iff (rst)
        (irq_flag[1] && !irq_clr[1]) |=> irq_flag[1]);

    // R8: the summary interrupt follows the flags
    a_r8_irq_or: assert property (@(posedge clk) disable iff (rst)
        irq == (|irq_flag));

endmodule

bind cc_line_inserter cc_line_inserter_chk #(
    .LINE_W    (LINE_W),
    .POS_W     (POS_W),
    .LEVEL_W   (LEVEL_W),
    .BIT_PCLK  (BIT_PCLK),
    .START_OFS (START_OFS),
    .LINE_F1   (LINE_F1),
    .LINE_F2   (LINE_F2),
    .LVL_BLANK (LVL_BLANK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_num   (line_num),
    .sample_pos (sample_pos),
    .irq_clr    (irq_clr),
    .cc_level   (cc_level),
    .cc_sel     (cc_sel),
    .irq_flag   (irq_flag),
    .irq        (irq)
);

// File: tb/tb_cc_line_inserter.sv
`timescale 1ns/1ps
module tb_cc_line_inserter;

    localparam int P     = 8;
    localparam int OFS   = 10;
    localparam int F1    = 21;
    localparam int F2    = 284;
    localparam int TOTAL = 26 * P;
    localparam int LEN   = OFS + TOTAL + 6;
    localparam logic [9:0] BLANK = 10'd240;
    localparam logic [9:0] HIGH  = 10'd560;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  line_num = '0;
    logic [11:0] sample_pos = '0;
    logic [1:0]  cap_en = '0;
    logic [1:0]  host_wr = '0;
    logic [13:0] host_pair_f1 = '0;
    logic [13:0] host_pair_f2 = '0;
    logic [1:0]  irq_clr = '0;
    logic [9:0]  cc_level;
    logic        cc_sel;
    logic [1:0]  irq_flag;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [13:0] m_pair [2];
    bit          m_fresh [2];
    logic [1:0]  m_irq;

    always #2.5 clk = ~clk;

    cc_line_inserter #(
        .BIT_PCLK (P),
        .START_OFS(OFS),
        .LINE_F1  (F1),
        .LINE_F2  (F2),
        .LVL_BLANK(BLANK),
        .LVL_HIGH (HIGH)
    ) dut (
        .clk(clk), .rst(rst), .line_num(line_num), .sample_pos(sample_pos),
        .cap_en(cap_en), .host_wr(host_wr), .host_pair_f1(host_pair_f1),
        .host_pair_f2(host_pair_f2), .irq_clr(irq_clr), .cc_level(cc_level),
        .cc_sel(cc_sel), .irq_flag(irq_flag), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_frame(input logic [13:0] pr, input bit fr);
        logic [6:0] c1, c2;
        c1 = pr[6:0];
        c2 = pr[13:7];
        if (!fr) return 16'h8080;
        return {~(^c2), c2, ~(^c1), c1};
    endfunction

    function automatic bit exp_bit(input int k, input logic [15:0] fr);
        int b, px;
        b  = k / P;
        px = k % P;
        if (b < 7)  return (px < P / 2);
        if (b < 9)  return 1'b0;
        if (b == 9) return 1'b1;
        return fr[b - 10];
    endfunction

    task automatic run_line(input int ln, input int wr_at, input int wr_f,
                            input logic [13:0] wr_val, input int clr_at,
                            input int clr_f, input string tag);
        int f;
        bit sent;
        logic [15:0] fr;
        int nerr;
        f = -1;
        sent = 0;
        fr = '0;
        nerr = 0;
        if (ln == F1 && cap_en[0]) f = 0;
        if (ln == F2 && cap_en[1]) f = 1;
        @(negedge clk);
        line_num = 10'(ln);
        for (int p = 0; p <= LEN; p++) begin
            if (p > 0) begin
                int k;
                bit es;
                logic [9:0] el;
                k  = p - 1 - OFS;
                es = sent && k >= 0 && k < TOTAL;
                el = (es && exp_bit(k, fr)) ? HIGH : BLANK;
                if (cc_sel !== es || cc_level !== el) begin
                    nerr++;
                    if (nerr <= 3)
                        check(0, {tag, " R2/R4/R5/R6/R9 waveform"}, int'(cc_level), int'(el));
                end
            end
            if (p == LEN) break;
            host_wr = '0;
            irq_clr = '0;
            sample_pos = 12'(p);
            if (p == OFS && f >= 0) begin
                sent = 1;
                fr = exp_frame(m_pair[f], m_fresh[f]);
                m_fresh[f] = 0;
            end
            if (p == wr_at) begin
                host_wr[wr_f] = 1'b1;
                if (wr_f == 0) host_pair_f1 = wr_val; else host_pair_f2 = wr_val;
                m_pair[wr_f] = wr_val;
                m_fresh[wr_f] = 1;
            end
            if (p == clr_at) begin
                irq_clr[clr_f] = 1'b1;
                m_irq[clr_f] = 1'b0;
            end
            if (sent && p == OFS + TOTAL) m_irq[f] = 1'b1;
            @(negedge clk);
        end
        host_wr = '0;
        irq_clr = '0;
        sample_pos = '0;
        line_num = '0;
        check(nerr == 0, {tag, " R2/R4/R5/R6/R9 waveform samples"}, nerr, 0);
        check(irq_flag === m_irq, {tag, " R8 irq_flag"}, int'(irq_flag), int'(m_irq));
        check(irq === (|m_irq), {tag, " R8 irq"}, int'(irq), int'(|m_irq));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_pair[0] = '0; m_pair[1] = '0;
        m_fresh[0] = 0; m_fresh[1] = 0;
        m_irq = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cc_sel === 1'b0, "R1 sel", int'(cc_sel), 0);
        check(cc_level === BLANK, "R1 level", int'(cc_level), int'(BLANK));
        check(irq_flag === 2'b00, "R1 irq_flag", int'(irq_flag), 0);
        check(irq === 1'b0, "R1 irq", int'(irq), 0);

        // R2 R6: first field with loaded pair
        cap_en = 2'b11;
        run_line(F1, 2, 0, {7'h45, 7'h13}, -1, 0, "R2 R6 f1 data");
        // R7: no reload gives null characters
        run_line(F1, -1, 0, '0, -1, 0, "R7 f1 null");
        // R8: flag still set with no clear, then clear
        repeat (5) @(negedge clk);
        check(irq_flag[0] === 1'b1, "R8 hold", int'(irq_flag[0]), 1);
        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        m_irq[0] = 1'b0;
        @(negedge clk);
        check(irq_flag[0] === 1'b0, "R8 clear", int'(irq_flag[0]), 0);

        // R3: second field disabled keeps its pair and flag
        cap_en = 2'b01;
        run_line(F2, 3, 1, {7'h7F, 7'h2A}, -1, 0, "R3 f2 disabled");
        check(cc_sel === 1'b0, "R3 no window", int'(cc_sel), 0);
        cap_en = 2'b10;
        run_line(F1, -1, 0, '0, -1, 0, "R3 f1 disabled");
        run_line(F2, -1, 0, '0, -1, 0, "R3 R6 f2 keeps pair");
        cap_en = 2'b11;
        run_line(100, 5, 0, {7'h01, 7'h00}, -1, 0, "R3 other line");

        // R10: write during transmission, then used next line
        run_line(F1, OFS + 12 * P, 0, {7'h55, 7'h6B}, -1, 0, "R10 mid write");
        run_line(F1, -1, 0, '0, -1, 0, "R10 next line");

        // R8: clear on the same edge as the set, set wins
        run_line(F2, 1, 1, {7'h31, 7'h0E}, OFS + TOTAL, 1, "R8 set beats clear");
        check(irq_flag[1] === 1'b1, "R8 set wins", int'(irq_flag[1]), 1);
        // R7: write on the start edge keeps the new pair fresh
        run_line(F1, OFS, 0, {7'h22, 7'h19}, 3, 0, "R7 write at start");
        run_line(F1, -1, 0, '0, -1, 0, "R7 R10 pair from start write");

        // random mix
        for (int i = 0; i < 16; i++) begin
            int sel, ln, wa, wf, ca, cf;
            sel = int'($urandom % 5);
            ln  = (sel < 2) ? F1 : (sel < 4) ? F2 : 33;
            cap_en = 2'($urandom);
            wa = ($urandom % 2) ? int'($urandom % LEN) : -1;
            wf = int'($urandom % 2);
            ca = ($urandom % 2) ? int'($urandom % LEN) : -1;
            cf = int'($urandom % 2);
            run_line(ln, wa, wf, 14'($urandom), ca, cf, "R2 R6 R7 R8 random");
        end

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule